// File: doc/BRIEF.md
# Power-Down and Clock-Stop Controller

This block keeps the per-peripheral clock-stop state of a small processor subsystem and runs its light sleep state. A 32-bit stop register holds one bit per peripheral clock; a stop bit at 1 drops the matching clock enable, and a stop bit at 0 lets that clock run. Software never writes the stop register directly. It writes ones to a set register to stop clocks and ones to a write-only clear register to restart them. A zero bit in either word leaves the matching stop bit alone, so no read-modify-write is needed.

The CPU signals that it has run its sleep instruction with a one-cycle request. If the standby-select control bit is 0, the controller moves to sleep on the next edge. In sleep it removes the CPU clock enable, so the CPU halts and keeps its registers. The peripheral clock enables and the register port keep working. A two-bit status output reports the mode. Any interrupt that is both requested and enabled, or a reset request, ends sleep on the next edge. A sleep request while standby-select is 1 is refused and reported on a separate output.

Top module: `pwr_clkstop_ctrl`

## Requirements
- R1: After reset the stop register reads 0, every peripheral clock enable is 1, the CPU clock enable is 1, status is 2'b00 and the standby-select bit reads 0.
- R2: A write to address 1 (set) makes every stop bit whose data bit is 1 equal to 1 and leaves the others as they were. Each periph_clk_en[i] equals the inverse of stop bit i from the edge that takes the write.
- R3: A write to address 2 (clear) makes every stop bit whose data bit is 1 equal to 0 and leaves the others as they were.
- R4: Address 0 reads the stop register, and a write to address 0 has no effect. Addresses 1 and 2 read as 0.
- R5: Address 3 holds standby-select in data bit 0. It reads back in bit 0, and all other bits read 0.
- R6: In run mode, a sleep_req with standby-select 0 puts the block into sleep on that edge: status becomes 2'b10 (status[1]=1, status[0]=0) and cpu_clk_en becomes 0.
- R7: In sleep, the peripheral clock enables keep following the stop register, and set and clear writes still take effect.
- R8: In sleep, a cycle in which any bit of irq_req AND irq_en is 1, or wake_rst is 1, returns the block to run on that edge: cpu_clk_en=1 and status=2'b00. Requested interrupts that are not enabled do not wake the block.
- R9: In run mode, a sleep_req with standby-select 1 leaves the block in run. stby_reject is 1 for the one cycle after the request and 0 otherwise.
- R10: In run mode, status is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| sleep_req | input | 1 | One-cycle sleep request from the CPU |
| irq_req | input | 8 | Interrupt requests |
| irq_en | input | 8 | Interrupt enables |
| wake_rst | input | 1 | Reset request, ends sleep |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 32 | Per-peripheral clock enables |
| status | output | 2 | Mode status: 00 run, 10 sleep |
| stby_reject | output | 1 | Sleep request refused because standby-select is 1 |

## Verification
A wrong stop bit shows at once on periph_clk_en and on a read of address 0, so the bench compares both after every set or clear write. A wrong mode state shows on status and cpu_clk_en at the first edge after a sleep request or wake event, and the bench samples on that cycle. It also holds a disabled interrupt for several cycles, which catches a wake term that ignores irq_en. Standby refusal is checked on the one cycle where stby_reject must pulse and on the cycle after it.

// File: rtl/pwr_clkstop_pkg.sv
package pwr_clkstop_pkg;

   // Register addresses (low bits of the address bus)
   localparam int unsigned REG_STOP = 0;
   localparam int unsigned REG_SET  = 1;
   localparam int unsigned REG_CLR  = 2;
   localparam int unsigned REG_CTRL = 3;

   // Bit of the control word that carries standby-select
   localparam int unsigned CTRL_STBY_BIT = 0;

   typedef enum logic [0:0] {
      MODE_RUN   = 1'b0,
      MODE_SLEEP = 1'b1
   } pcs_mode_e;

   // Status pin encodings
   localparam logic [1:0] STAT_RUN   = 2'b00;
   localparam logic [1:0] STAT_SLEEP = 2'b10;

endpackage

// File: rtl/pcs_stop_bank.sv
module pcs_stop_bank #(
   parameter int unsigned DATA_W   = 32,
   parameter bit          CLR_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] set_mask,
   input  logic [DATA_W-1:0] clr_mask,
   output logic [DATA_W-1:0] stop_q
);

   initial begin
      if (DATA_W < 1) $error("pcs_stop_bank: DATA_W must be at least 1");
   end

   // One flop per clock-stop bit; the priority between a set and a clear
   // on the same bit in the same cycle is picked by CLR_WINS.
   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (CLR_WINS) begin : g_clr_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           stop_q[i] <= 1'b0;
            else if (clr_mask[i]) stop_q[i] <= 1'b0;
            else if (set_mask[i]) stop_q[i] <= 1'b1;
         end
      end else begin : g_set_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           stop_q[i] <= 1'b0;
            else if (set_mask[i]) stop_q[i] <= 1'b1;
            else if (clr_mask[i]) stop_q[i] <= 1'b0;
         end
      end
   end

   // R3: every bit named by a clear word is 0 after the edge
   p_clear_hits_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (|clr_mask) |=> ((stop_q & $past(clr_mask)) == '0));

   // R2: bits named only by a set word are 1 after the edge
   p_set_hits_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (|(set_mask & ~clr_mask)) |=>
         ((stop_q & $past(set_mask & ~clr_mask)) == $past(set_mask & ~clr_mask)));

   // R2/R3: without a set or clear the register holds
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_mask == '0) && (clr_mask == '0)) |=> $stable(stop_q));

endmodule

// File: rtl/pcs_regif.sv
module pcs_regif
   import pwr_clkstop_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] stop_q,
   output logic [DATA_W-1:0] set_mask,
   output logic [DATA_W-1:0] clr_mask,
   output logic              stby_sel,
   output logic [DATA_W-1:0] rd_data
);

   localparam logic [ADDR_W-1:0] A_STOP = ADDR_W'(REG_STOP);
   localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(REG_SET);
   localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(REG_CLR);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(REG_CTRL);

   initial begin
      if (ADDR_W < 2)             $error("pcs_regif: ADDR_W must be at least 2");
      if (DATA_W <= CTRL_STBY_BIT) $error("pcs_regif: DATA_W too narrow for control word");
   end

   logic wr_set, wr_clr, wr_ctrl;

   always_comb begin
      wr_set  = wr_en && (wr_addr == A_SET);
      wr_clr  = wr_en && (wr_addr == A_CLR);
      wr_ctrl = wr_en && (wr_addr == A_CTRL);
      set_mask = wr_set ? wr_data : '0;
      clr_mask = wr_clr ? wr_data : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       stby_sel <= 1'b0;
      else if (wr_ctrl) stby_sel <= wr_data[CTRL_STBY_BIT];
   end

   // Set and clear are write-only and read back as zero.
   always_comb begin
      rd_data = '0;
      unique case (rd_addr)
         A_STOP:  rd_data = stop_q;
         A_CTRL:  rd_data[CTRL_STBY_BIT] = stby_sel;
         default: rd_data = '0;
      endcase
   end

   // R5: standby-select takes bit 0 of a control write
   p_ctrl_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> (stby_sel == $past(wr_data[CTRL_STBY_BIT])));

   // R4: a write to the stop address produces neither mask
   p_stop_wr_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_STOP) |-> ((set_mask == '0) && (clr_mask == '0)));

endmodule

// File: rtl/pcs_sleep_fsm.sv
module pcs_sleep_fsm
   import pwr_clkstop_pkg::*;
#(
   parameter int unsigned IRQ_W         = 8,
   parameter bit          REJECT_REGGED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sleep_req,
   input  logic             stby_sel,
   input  logic [IRQ_W-1:0] irq_req,
   input  logic [IRQ_W-1:0] irq_en,
   input  logic             wake_rst,
   output logic             cpu_clk_en,
   output logic [1:0]       status,
   output logic             stby_reject
);

   initial begin
      if (IRQ_W < 1) $error("pcs_sleep_fsm: IRQ_W must be at least 1");
   end

   pcs_mode_e mode_q, mode_d;
   logic      wake, enter, refuse;

   always_comb begin
      wake   = (|(irq_req & irq_en)) || wake_rst;
      enter  = (mode_q == MODE_RUN) && sleep_req && !stby_sel;
      refuse = (mode_q == MODE_RUN) && sleep_req &&  stby_sel;
      mode_d = mode_q;
      unique case (mode_q)
         MODE_RUN:   if (enter) mode_d = MODE_SLEEP;
         MODE_SLEEP: if (wake)  mode_d = MODE_RUN;
         default:    mode_d = MODE_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= MODE_RUN;
      else        mode_q <= mode_d;
   end

   always_comb begin
      cpu_clk_en = (mode_q == MODE_RUN);
      status     = (mode_q == MODE_SLEEP) ? STAT_SLEEP : STAT_RUN;
   end

   if (REJECT_REGGED) begin : g_reject_reg
      logic rej_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rej_q <= 1'b0;
         else        rej_q <= refuse;
      end
      assign stby_reject = rej_q;

      // R9: refusal pulses on the cycle after the request
      p_reject_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
         refuse |=> stby_reject);
   end else begin : g_reject_comb
      assign stby_reject = refuse;
   end

   // R6: accepted request enters sleep with the CPU clock off
   p_sleep_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
      enter |=> (status == STAT_SLEEP) && !cpu_clk_en);

   // R8: a wake event in sleep restores run on the next edge
   p_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_q == MODE_SLEEP) && wake) |=> cpu_clk_en && (status == STAT_RUN));

   // R8: without a wake event sleep persists
   p_stay_asleep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_q == MODE_SLEEP) && !wake) |=> (status == STAT_SLEEP));

   // R9: a refused request leaves the block running
   p_no_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
      refuse |=> (status == STAT_RUN) && cpu_clk_en);

   // R10: the CPU clock enable and the status code agree
   p_status_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_clk_en |-> (status == STAT_RUN));

endmodule

// File: rtl/pwr_clkstop_ctrl.sv
module pwr_clkstop_ctrl
   import pwr_clkstop_pkg::*;
#(
   parameter int unsigned DATA_W        = 32,
   parameter int unsigned ADDR_W        = 3,
   parameter int unsigned IRQ_W         = 8,
   parameter bit          CLR_WINS      = 1'b1,
   parameter bit          REJECT_REGGED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              sleep_req,
   input  logic [IRQ_W-1:0]  irq_req,
   input  logic [IRQ_W-1:0]  irq_en,
   input  logic              wake_rst,
   output logic              cpu_clk_en,
   output logic [DATA_W-1:0] periph_clk_en,
   output logic [1:0]        status,
   output logic              stby_reject
);

   logic [DATA_W-1:0] set_mask, clr_mask, stop_q;
   logic              stby_sel;

   pcs_regif #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regif (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .rd_addr  (rd_addr),
      .stop_q   (stop_q),
      .set_mask (set_mask),
      .clr_mask (clr_mask),
      .stby_sel (stby_sel),
      .rd_data  (rd_data)
   );

   pcs_stop_bank #(.DATA_W(DATA_W), .CLR_WINS(CLR_WINS)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_mask (set_mask),
      .clr_mask (clr_mask),
      .stop_q   (stop_q)
   );

   pcs_sleep_fsm #(.IRQ_W(IRQ_W), .REJECT_REGGED(REJECT_REGGED)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .sleep_req   (sleep_req),
      .stby_sel    (stby_sel),
      .irq_req     (irq_req),
      .irq_en      (irq_en),
      .wake_rst    (wake_rst),
      .cpu_clk_en  (cpu_clk_en),
      .status      (status),
      .stby_reject (stby_reject)
   );

   // Peripheral enables ignore the sleep state on purpose.
   assign periph_clk_en = ~stop_q;

   // R7: peripheral enables stay tied to the stop bits in any mode
   p_periph_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (status == STAT_SLEEP) |-> (periph_clk_en == ~u_bank.stop_q));

endmodule

// File: tb/pwr_clkstop_ctrl_bench.sv
module pwr_clkstop_ctrl_bench;

   localparam int DW = 32;
   localparam int AW = 3;
   localparam int IW = 8;
   localparam int NV = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic          sleep_req = 1'b0;
   logic [IW-1:0] irq_req = '0;
   logic [IW-1:0] irq_en = '0;
   logic          wake_rst = 1'b0;
   logic          cpu_clk_en;
   logic [DW-1:0] periph_clk_en;
   logic [1:0]    status;
   logic          stby_reject;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   pwr_clkstop_ctrl u_pwr_clkstop_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .sleep_req(sleep_req), .irq_req(irq_req), .irq_en(irq_en),
      .wake_rst(wake_rst), .cpu_clk_en(cpu_clk_en),
      .periph_clk_en(periph_clk_en), .status(status),
      .stby_reject(stby_reject)
   );

   // {address, write data, expected stop register afterwards}
   localparam logic [AW+2*DW-1:0] VEC [NV] = '{
      {3'd1, 32'h0000_00FF, 32'h0000_00FF},
      {3'd1, 32'hF000_0000, 32'hF000_00FF},
      {3'd2, 32'h0000_000F, 32'hF000_00F0},
      {3'd2, 32'h0000_0000, 32'hF000_00F0},
      {3'd1, 32'h0000_0000, 32'hF000_00F0},
      {3'd0, 32'hFFFF_FFFF, 32'hF000_00F0},
      {3'd2, 32'h8000_0010, 32'h7000_00E0},
      {3'd1, 32'h0001_0001, 32'h7001_00E1},
      {3'd2, 32'hFFFF_FFFF, 32'h0000_0000},
      {3'd1, 32'hA5A5_5A5A, 32'hA5A5_5A5A}
   };

   task automatic check(input string tag, input logic [DW-1:0] act,
                        input logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Drive a write on a falling edge; it lands on the next rising edge.
   task automatic reg_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic read_at(input logic [AW-1:0] a, output logic [DW-1:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   logic [DW-1:0] rv;
   logic [DW-1:0] stop_model;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      read_at(3'd0, rv);
      check("R1 stop reset", rv, '0);
      check("R1 periph enables", periph_clk_en, '1);
      check("R1 cpu_clk_en", {31'd0, cpu_clk_en}, 32'd1);
      check("R1 status", {30'd0, status}, 32'd0);
      read_at(3'd3, rv);
      check("R1 stby_sel", rv, '0);

      // R2 R3 R4: table walk of set, clear and ignored writes
      for (int i = 0; i < NV; i++) begin
         reg_write(VEC[i][AW+2*DW-1 -: AW], VEC[i][2*DW-1 -: DW]);
         read_at(3'd0, rv);
         check($sformatf("R2/R3/R4 vector %0d stop", i), rv, VEC[i][DW-1:0]);
         check($sformatf("R2 vector %0d periph", i), periph_clk_en, ~VEC[i][DW-1:0]);
      end
      stop_model = 32'hA5A5_5A5A;

      // R4: write-only registers read zero
      read_at(3'd1, rv);
      check("R4 set reads 0", rv, '0);
      read_at(3'd2, rv);
      check("R4 clear reads 0", rv, '0);

      // R5: control bit 0 only
      reg_write(3'd3, 32'hFFFF_FFFF);
      read_at(3'd3, rv);
      check("R5 ctrl readback", rv, 32'd1);
      reg_write(3'd3, 32'hFFFF_FFFE);
      read_at(3'd3, rv);
      check("R5 ctrl clear", rv, 32'd0);

      // R10: run status
      check("R10 run status", {30'd0, status}, 32'd0);

      // R6: sleep entry with a disabled interrupt already pending
      irq_req = 8'hFF; irq_en = 8'h00;
      @(negedge clk);
      sleep_req = 1'b1;
      @(negedge clk);
      sleep_req = 1'b0;
      check("R6 status sleep", {30'd0, status}, 32'd2);
      check("R6 cpu_clk_en off", {31'd0, cpu_clk_en}, 32'd0);

      // R8: requested but disabled interrupts keep it asleep
      repeat (3) @(negedge clk);
      check("R8 disabled irq no wake", {30'd0, status}, 32'd2);

      // R7: clear and set still act while asleep
      reg_write(3'd2, 32'h0000_000A);
      stop_model = stop_model & ~32'h0000_000A;
      check("R7 periph during sleep", periph_clk_en, ~stop_model);
      reg_write(3'd1, 32'h0000_0100);
      stop_model = stop_model | 32'h0000_0100;
      read_at(3'd0, rv);
      check("R7 stop during sleep", rv, stop_model);
      check("R7 still asleep", {30'd0, status}, 32'd2);

      // R8: one enabled bit wakes on the next edge
      irq_req = 8'h04; irq_en = 8'h04;
      @(negedge clk);
      check("R8 irq wake status", {30'd0, status}, 32'd0);
      check("R8 irq wake cpu", {31'd0, cpu_clk_en}, 32'd1);
      irq_req = '0; irq_en = '0;

      // R8: reset request wakes
      sleep_req = 1'b1;
      @(negedge clk);
      sleep_req = 1'b0;
      check("R6 second entry", {30'd0, status}, 32'd2);
      wake_rst = 1'b1;
      @(negedge clk);
      wake_rst = 1'b0;
      check("R8 wake_rst status", {30'd0, status}, 32'd0);

      // R9: refusal when standby-select is 1
      reg_write(3'd3, 32'd1);
      check("R9 no reject before", {31'd0, stby_reject}, 32'd0);
      sleep_req = 1'b1;
      @(negedge clk);
      sleep_req = 1'b0;
      check("R9 stays run", {30'd0, status}, 32'd0);
      check("R9 cpu stays on", {31'd0, cpu_clk_en}, 32'd1);
      check("R9 reject pulse", {31'd0, stby_reject}, 32'd1);
      @(negedge clk);
      check("R9 reject ends", {31'd0, stby_reject}, 32'd0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule